// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block gathers the event reporting of an I2C master controller into one set of status registers and a single interrupt line. The bus engine delivers twelve event sources as one-cycle pulses. Two of the sources are levels taken straight from FIFO thresholds. The block latches the pulsed sources, combines them with the levels into a raw status word, and gates that word with a writable enable mask to form a masked view. The interrupt output is the registered OR of the masked view.

Software clears latched events by reading. Each source has its own clearing address, and one more address clears every latched source at once. When a transfer is aborted, the engine presents a cause vector together with the tx-abort pulse. The block accumulates that vector into an abort-cause register. A general clear leaves this register alone, and only a read of the tx-abort clearing address empties it. Register access is a simple synchronous port: read and write strobes, a word address, write data, and read data that is registered.

Top module: `i2c_irq_status_unit`

## Requirements
- R1: A pulse on `evt_pulse[n]` for a latched source sets raw status bit n from the next cycle onward. Bit meanings: 0 rx underflow, 1 rx overflow, 2 rx threshold reached, 3 tx overflow, 4 tx threshold reached, 5 read request, 6 tx abort, 7 rx done, 8 bus activity, 9 stop seen, 10 start seen, 11 general call. The raw status word is read at address 1.
- R2: Raw bits 2 and 4 follow `lvl_in[2]` and `lvl_in[4]` directly. Pulses on `evt_pulse[2]` and `evt_pulse[4]` are ignored, and reads of their clearing addresses (7 and 9) leave them unchanged.
- R3: Address 2 is the read/write enable mask, with reset value 0x254 (bits 2, 4, 6 and 9). Address 0 returns the raw status ANDed with the mask.
- R4: A read of address 5+n clears only latched bit n and returns 0.
- R5: A read of address 4 clears every latched raw bit and returns 0. It does not change the abort-cause register.
- R6: On a pulse of `evt_pulse[6]`, `abort_cause` is ORed into the abort-cause register, which is read at address 3. Cause bits: 0 7-bit address nack, 1 first 10-bit address byte nack, 2 second 10-bit address byte nack, 3 data nack, 4 general-call nack, 5 read after general call, 7 start byte acknowledged, 9 start byte with restart off, 10 10-bit read with restart off, 11 master disabled, 12 arbitration lost.
- R7: The abort-cause register holds its value until address 11 (the tx-abort clear) is read. That read zeroes it, unless a new abort arrives in the same cycle, in which case the register takes the new cause.
- R8: When an event pulse and a clearing read of the same bit fall in the same cycle, the bit stays set.
- R9: `irq` equals the OR of the masked status bits as they stood in the previous cycle.
- R10: `bus_rdata` is registered. It shows, one cycle after a read strobe, the value before any clear that the read causes. Unmapped addresses and clearing addresses read as 0. After reset, raw status, abort cause, `bus_rdata` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 12 | One-cycle event pulses, one per source |
| lvl_in | input | 12 | Level conditions (only bits 2 and 4 are used) |
| abort_cause | input | 13 | Abort cause vector, valid with evt_pulse[6] |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
An event pulse sampled at a clock edge appears in the raw status word after that edge. A read issued at the following edge returns the status one edge later, and `irq` reflects the event one edge after the raw bit does. Clearing reads take effect at the strobe edge, yet the data they return reflects the state before the clear. The bench updates its behavioural model at each rising edge from the inputs sampled there. It compares `bus_rdata` and `irq` against the model at every falling edge. Directed reads are checked at the first falling edge after the strobe edge.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
   localparam int IDX_RX_FULL  = 2;
   localparam int IDX_TX_EMPTY = 4;
   localparam int IDX_TX_ABRT  = 6;

   localparam int ADR_MASKED   = 0;
   localparam int ADR_RAW      = 1;
   localparam int ADR_MASK     = 2;
   localparam int ADR_CAUSE    = 3;
   localparam int ADR_CLR_ALL  = 4;
   localparam int ADR_CLR_BASE = 5;
endpackage

// File: rtl/i2c_irq_src_bit.sv
module i2c_irq_src_bit #(
   parameter bit IS_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic lvl,
   input  logic clr,
   output logic stat
);
   generate
      if (IS_LEVEL) begin : g_level
         logic unused_lvl_path;
         assign unused_lvl_path = ^{evt, clr, clk, rst_n};
         assign stat = lvl;
      end else begin : g_latch
         logic stat_q;
         logic unused_lat_path;
         assign unused_lat_path = lvl;
         always_ff @(posedge clk) begin
            if (!rst_n)   stat_q <= 1'b0;
            else if (evt) stat_q <= 1'b1;
            else if (clr) stat_q <= 1'b0;
         end
         assign stat = stat_q;
      end
   endgenerate
endmodule

// File: rtl/i2c_irq_abort_cause.sv
module i2c_irq_abort_cause #(
   parameter int CAUSE_W = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic [CAUSE_W-1:0] cause_in,
   input  logic               clear,
   output logic [CAUSE_W-1:0] cause_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)                 cause_q <= '0;
      else if (capture && clear)  cause_q <= cause_in;
      else if (clear)             cause_q <= '0;
      else if (capture)           cause_q <= cause_q | cause_in;
   end
endmodule

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
   import i2c_irq_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int SRC_N  = 12
) (
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [SRC_N-1:0]  clr_one,
   output logic              clr_all
);
   assign clr_all = bus_rd && (bus_addr == ADDR_W'(ADR_CLR_ALL));

   generate
      for (genvar i = 0; i < SRC_N; i++) begin : g_clr
         assign clr_one[i] = bus_rd && (bus_addr == ADDR_W'(ADR_CLR_BASE + i));
      end
   endgenerate
endmodule

// File: rtl/i2c_irq_status_unit.sv
module i2c_irq_status_unit
   import i2c_irq_pkg::*;
#(
   parameter int              SRC_N     = 12,
   parameter int              CAUSE_W   = 13,
   parameter int              ADDR_W    = 5,
   parameter int              DATA_W    = 32,
   parameter logic [SRC_N-1:0] LEVEL_SRC = 12'h014,
   parameter logic [SRC_N-1:0] MASK_RST  = 12'h254
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SRC_N-1:0]   evt_pulse,
   input  logic [SRC_N-1:0]   lvl_in,
   input  logic [CAUSE_W-1:0] abort_cause,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq
);
   localparam int ADDR_SPAN = ADR_CLR_BASE + SRC_N;

   generate
      if (CAUSE_W >= DATA_W || SRC_N >= CAUSE_W) begin : g_bad_width
         $error("widths must satisfy SRC_N < CAUSE_W < DATA_W");
      end
      if ((2 ** ADDR_W) < ADDR_SPAN) begin : g_bad_addr
         $error("ADDR_W too narrow for the clear addresses");
      end
      if (IDX_TX_ABRT >= SRC_N) begin : g_bad_idx
         $error("tx abort index outside source range");
      end
   endgenerate

   logic [SRC_N-1:0]   raw_stat;
   logic [SRC_N-1:0]   mask_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [SRC_N-1:0]   clr_one;
   logic               clr_all;
   logic [DATA_W-1:0]  rd_next;
   logic               unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:SRC_N];

   i2c_irq_decode #(.ADDR_W(ADDR_W), .SRC_N(SRC_N)) u_decode (
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .clr_one  (clr_one),
      .clr_all  (clr_all)
   );

   generate
      for (genvar i = 0; i < SRC_N; i++) begin : g_src
         i2c_irq_src_bit #(.IS_LEVEL(LEVEL_SRC[i])) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_pulse[i]),
            .lvl   (lvl_in[i]),
            .clr   (clr_one[i] | clr_all),
            .stat  (raw_stat[i])
         );
      end
   endgenerate

   i2c_irq_abort_cause #(.CAUSE_W(CAUSE_W)) u_cause (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (evt_pulse[IDX_TX_ABRT]),
      .cause_in (abort_cause),
      .clear    (clr_one[IDX_TX_ABRT]),
      .cause_q  (cause_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= MASK_RST;
      else if (bus_wr && bus_addr == ADDR_W'(ADR_MASK)) mask_q <= bus_wdata[SRC_N-1:0];
   end

   always_comb begin
      rd_next = '0;
      if (bus_addr == ADDR_W'(ADR_MASKED))     rd_next = DATA_W'(raw_stat & mask_q);
      else if (bus_addr == ADDR_W'(ADR_RAW))   rd_next = DATA_W'(raw_stat);
      else if (bus_addr == ADDR_W'(ADR_MASK))  rd_next = DATA_W'(mask_q);
      else if (bus_addr == ADDR_W'(ADR_CAUSE)) rd_next = DATA_W'(cause_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         irq       <= 1'b0;
      end else begin
         if (bus_rd) bus_rdata <= rd_next;
         irq <= |(raw_stat & mask_q);
      end
   end
endmodule

module i2c_irq_status_chk
   import i2c_irq_pkg::*;
#(
   parameter int               SRC_N     = 12,
   parameter int               CAUSE_W   = 13,
   parameter int               ADDR_W    = 5,
   parameter int               DATA_W    = 32,
   parameter logic [SRC_N-1:0] LEVEL_SRC = 12'h014
) (
   input logic               clk,
   input logic               rst_n,
   input logic [SRC_N-1:0]   evt_pulse,
   input logic               bus_rd,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               irq,
   input logic [SRC_N-1:0]   raw_stat,
   input logic [SRC_N-1:0]   mask_q,
   input logic [CAUSE_W-1:0] cause_q
);
   AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_pulse & ~LEVEL_SRC)) |=>
      ((raw_stat & $past(evt_pulse & ~LEVEL_SRC)) == $past(evt_pulse & ~LEVEL_SRC))); // R1
   AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(ADR_MASKED)) |=>
      (bus_rdata == DATA_W'($past(raw_stat & mask_q)))); // R3
   AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(ADR_CLR_ALL) && evt_pulse == '0) |=>
      ((raw_stat & ~LEVEL_SRC) == '0)); // R5
   AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_rd && bus_addr == ADDR_W'(ADR_CLR_BASE + IDX_TX_ABRT)) && !evt_pulse[IDX_TX_ABRT]) |=>
      $stable(cause_q)); // R7
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|(raw_stat & mask_q)) |=> irq); // R9
   AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(raw_stat & mask_q)) |=> !irq); // R9
endmodule

bind i2c_irq_status_unit i2c_irq_status_chk #(
   .SRC_N(SRC_N), .CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .LEVEL_SRC(LEVEL_SRC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq),
   .raw_stat(raw_stat), .mask_q(mask_q), .cause_q(cause_q)
);

// File: tb/test_i2c_irq_status_unit.sv
module test_i2c_irq_status_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] evt = '0;
   logic [11:0] lvl = '0;
   logic [12:0] cause = '0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int total = 0;
   int bad = 0;

   int m_lat, m_mask, m_cause, m_rdata, m_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_irq_status_unit i_i2c_irq_status_unit (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt), .lvl_in(lvl),
      .abort_cause(cause), .bus_rd(rd), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
   );

   // behavioural reference
   always @(posedge clk) begin
      int raw;
      if (!rst_n) begin
         m_lat = 0; m_mask = 'h254; m_cause = 0; m_rdata = 0; m_irq = 0;
      end else begin
         raw = (m_lat & ~'h14) | (lvl[2] ? 4 : 0) | (lvl[4] ? 16 : 0);
         if (rd) begin
            case (addr)
               0: m_rdata = raw & m_mask;
               1: m_rdata = raw;
               2: m_rdata = m_mask;
               3: m_rdata = m_cause;
               default: m_rdata = 0;
            endcase
         end
         m_irq = ((raw & m_mask) != 0) ? 1 : 0;
         if (rd && addr == 4) m_lat = 0;
         if (rd && addr >= 5 && addr <= 16) m_lat = m_lat & ~(1 << (addr - 5));
         m_lat = (m_lat | evt) & ~'h14;
         if (rd && addr == 11) m_cause = 0;
         if (evt[6]) m_cause = m_cause | cause;
         if (wr && addr == 2) m_mask = wdata & 'hfff;
      end
   end

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R10 rdata vs model", rdata, m_rdata);
         check("R9 irq vs model", irq, m_irq);
      end
   end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(logic [11:0] e, logic [12:0] c);
      evt = e; cause = c;
      @(negedge clk);
      evt = '0; cause = '0;
   endtask

   task automatic rd_chk(logic [4:0] a, int exp, string tag);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0;
      check(tag, rdata, exp);
   endtask

   task automatic write(logic [4:0] a, logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      check("R10 reset rdata", rdata, 0);
      check("R10 reset irq", irq, 0);
      rd_chk(2, 'h254, "R3 mask reset value");
      rd_chk(1, 0, "R10 raw zero after reset");
      rd_chk(3, 0, "R10 cause zero after reset");

      pulse(12'h201, '0);
      rd_chk(1, 'h201, "R1 raw after rx_under and stop pulses");
      rd_chk(0, 'h200, "R3 masked view");
      check("R9 irq with stop enabled", irq, 1);

      rd_chk(5, 0, "R4 clear read returns zero");
      rd_chk(1, 'h200, "R4 only bit 0 cleared");

      lvl[2] = 1'b1;
      pulse(12'h010, '0);
      rd_chk(1, 'h204, "R2 level bit follows, tx_empty pulse ignored");
      rd_chk(7, 0, "R2 clear of level source");
      rd_chk(1, 'h204, "R2 level bit unchanged by clear");
      lvl[2] = 1'b0;

      pulse(12'h040, 13'h1001);
      rd_chk(3, 'h1001, "R6 cause captured");
      rd_chk(4, 0, "R5 clear all returns zero");
      rd_chk(1, 0, "R5 all latched bits cleared");
      rd_chk(3, 'h1001, "R5 cause kept over clear all");
      pulse(12'h040, 13'h0008);
      rd_chk(3, 'h1009, "R6 cause accumulates");
      rd_chk(11, 0, "R7 cause clear read returns zero");
      rd_chk(3, 0, "R7 cause zeroed");
      rd_chk(1, 0, "R4 tx_abrt bit cleared with cause");

      pulse(12'h008, '0);
      evt = 12'h008; rd = 1'b1; addr = 5'd8;
      @(negedge clk);
      evt = '0; rd = 1'b0;
      rd_chk(1, 'h008, "R8 event wins over clear");

      evt = 12'h040; cause = 13'h0800; rd = 1'b1; addr = 5'd11;
      @(negedge clk);
      evt = '0; cause = '0; rd = 1'b0;
      rd_chk(3, 'h0800, "R7 new cause wins over clear");

      write(2, 32'h0);
      idle(1);
      check("R9 irq low with all masked", irq, 0);
      rd_chk(0, 0, "R3 masked view all masked");
      write(2, 32'hfff);
      rd_chk(4, 0, "R5 clear all");
      rd_chk(11, 0, "R7 clear cause");
      idle(1);
      check("R9 irq low when empty", irq, 0);
      evt = 12'h800;
      @(negedge clk);
      evt = '0;
      check("R9 irq not yet set", irq, 0);
      @(negedge clk);
      check("R9 irq set one cycle after raw", irq, 1);
      rd_chk(0, 'h800, "R1 gen_call bit 11");

      rd_chk(31, 0, "R10 unmapped address");
      idle(2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule